// File: doc/BRIEF.md
# Fully Associative Translation Buffer with Protection Checks

The block turns a virtual page number into a physical page number by comparing the request against every stored translation at once. Two kinds of entry share one lookup: ordinary entries that each cover a single page, and a small set of range entries that each cover an aligned run of 2^k pages. Ordinary entries are installed by a miss walker and replaced in round-robin order. Range entries are written through their own install path into a chosen slot and are never displaced by ordinary installs.

Every access that hits goes through two permission stages. First, the entry's access identifier must be zero (shared) or equal to one of four per-process identifier inputs. Second, the entry's rights must allow the requested kind of access at the current privilege level. A request whose class (instruction fetch or data access) has its virtual-mode enable low skips translation and all checks entirely. Each request gets exactly one registered outcome one cycle later: hit, miss, protection fault or rights fault.

Top module: `xlat_buf`

## Requirements
- R1: After reset, `rsp_valid` is low and all ordinary and range entries are invalid, so the first virtual-mode lookup of any page reports a miss.
- R2: A request with `req_valid` high produces `rsp_valid` high on the next cycle with exactly one of `rsp_hit`, `rsp_miss`, `rsp_prot_flt`, `rsp_rights_flt` set; when `rsp_valid` is low all four are low.
- R3: The access kind is encoded in `req_kind` as 2'b00 read, 2'b01 write, 2'b10 execute. Execute uses `i_virt` as its mode enable, read and write use `d_virt`. With that enable low, the response is a hit whose `rsp_ppn` equals the low PPN_W bits of `req_vpn`, with no protection or rights check.
- R4: In virtual mode, a valid ordinary entry whose page number equals `req_vpn` supplies its stored physical page number on `rsp_ppn`, provided both checks pass.
- R5: A valid range entry with size field k matches when `req_vpn` and its base agree in all bits above bit k-1; the result is its physical base with the low k bits replaced by those of `req_vpn`. A matching range entry takes precedence over a matching ordinary entry.
- R6: The protection check passes when the entry's identifier is zero or equals `pid0`, `pid1`, `pid2` or `pid3`; otherwise the response is a protection fault.
- R7: `ins_rights` is laid out as [4] read, [3] write, [2] execute, [1:0] lowest privileged level allowed; level 0 is the most privileged and access requires `req_priv` less than or equal to that field and the permission bit for `req_kind` (kind 2'b11 is never permitted). A failure gives a rights fault; a protection failure takes precedence over it.
- R8: Ordinary installs (`ins_valid` with `ins_blk` low) fill slots 0 to NUM_ENT-1 in order and then wrap, overwriting the oldest; range installs (`ins_blk` high) neither move that order nor evict any ordinary entry.
- R9: In virtual mode, a page matched by no valid entry reports a miss with `rsp_ppn` zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Lookup request strobe |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_kind | input | 2 | Access kind: read, write, execute |
| req_priv | input | 2 | Current privilege level, 0 most privileged |
| d_virt | input | 1 | Virtual mode enable for data accesses |
| i_virt | input | 1 | Virtual mode enable for instruction fetches |
| pid0 | input | AID_W | Process protection identifier 0 |
| pid1 | input | AID_W | Process protection identifier 1 |
| pid2 | input | AID_W | Process protection identifier 2 |
| pid3 | input | AID_W | Process protection identifier 3 |
| ins_valid | input | 1 | Install strobe |
| ins_blk | input | 1 | Install targets a range entry |
| ins_bslot | input | BIDX_W | Range entry slot for a range install |
| ins_vpn | input | VPN_W | Virtual page (or range base) to install |
| ins_ppn | input | PPN_W | Physical page (or range base) to install |
| ins_rights | input | 5 | Permission bits and privilege field |
| ins_aid | input | AID_W | Access identifier of the entry |
| ins_sz | input | SZ_W | Range size as log2 of the page count |
| rsp_valid | output | 1 | Response strobe |
| rsp_hit | output | 1 | Translation granted (or bypassed) |
| rsp_miss | output | 1 | No valid entry matched |
| rsp_prot_flt | output | 1 | Identifier check failed |
| rsp_rights_flt | output | 1 | Rights or privilege check failed |
| rsp_ppn | output | PPN_W | Physical page number of a hit |

## Verification
The assertions assume reset is held high from time zero until the first edge, and that a range install names a slot below NUM_BLK with a size field smaller than PPN_W. The stimulus keeps range bases aligned to their size and drives request and install inputs only on the falling edge, holding each for one rising edge. The bench restores reset before the replacement scenario so the round-robin order starts from slot 0 in a known state.

// File: rtl/xb_pkg.sv
package xb_pkg;
  typedef enum logic [1:0] {
    XB_READ  = 2'b00,
    XB_WRITE = 2'b01,
    XB_EXEC  = 2'b10
  } xb_kind_e;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic       ex;
    logic [1:0] pl;
  } xb_rights_t;
endpackage

// File: rtl/xb_rr_ptr.sv
module xb_rr_ptr #(
  parameter int NUM_ENT = 8,
  localparam int IDX_W = $clog2(NUM_ENT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [IDX_W-1:0] ptr
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_ENT - 1);

  always_ff @(posedge clk) begin
    if (rst) ptr <= '0;
    else if (adv) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (rst)
    adv |=> ptr == (($past(ptr) == LAST) ? '0 : $past(ptr) + 1'b1)); // R8
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !adv |=> $stable(ptr)); // R8
endmodule

// File: rtl/xb_perm.sv
module xb_perm #(
  parameter int AID_W = 8
) (
  input  logic [AID_W-1:0] aid,
  input  logic [4:0]       rights,
  input  logic [AID_W-1:0] pid0,
  input  logic [AID_W-1:0] pid1,
  input  logic [AID_W-1:0] pid2,
  input  logic [AID_W-1:0] pid3,
  input  logic [1:0]       kind,
  input  logic [1:0]       priv,
  output logic             prot_ok,
  output logic             rights_ok
);
  import xb_pkg::*;
  xb_rights_t r;
  logic       perm;

  assign r = xb_rights_t'(rights);

  always_comb begin
    prot_ok = (aid == '0) || (aid == pid0) || (aid == pid1) ||
              (aid == pid2) || (aid == pid3);
    unique case (kind)
      XB_READ:  perm = r.rd;
      XB_WRITE: perm = r.wr;
      XB_EXEC:  perm = r.ex;
      default:  perm = 1'b0;
    endcase
    rights_ok = perm && (priv <= r.pl);
  end
endmodule

// File: rtl/xb_lookup.sv
module xb_lookup #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int AID_W   = 8,
  parameter int SZ_W    = 4,
  parameter int NUM_ENT = 8,
  parameter int NUM_BLK = 2,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int BIDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_norm,
  input  logic [IDX_W-1:0]  wr_slot,
  input  logic              wr_blk,
  input  logic [BIDX_W-1:0] wr_bslot,
  input  logic [VPN_W-1:0]  wr_vpn,
  input  logic [PPN_W-1:0]  wr_ppn,
  input  logic [4:0]        wr_rights,
  input  logic [AID_W-1:0]  wr_aid,
  input  logic [SZ_W-1:0]   wr_sz,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              found,
  output logic [PPN_W-1:0]  ppn,
  output logic [AID_W-1:0]  aid,
  output logic [4:0]        rights
);
  logic [NUM_ENT-1:0] n_vld;
  logic [VPN_W-1:0]   n_vpn [NUM_ENT];
  logic [PPN_W-1:0]   n_ppn [NUM_ENT];
  logic [4:0]         n_rt  [NUM_ENT];
  logic [AID_W-1:0]   n_aid [NUM_ENT];
  logic [NUM_ENT-1:0] n_hit;

  logic [NUM_BLK-1:0] b_vld;
  logic [VPN_W-1:0]   b_vpn  [NUM_BLK];
  logic [PPN_W-1:0]   b_ppn  [NUM_BLK];
  logic [4:0]         b_rt   [NUM_BLK];
  logic [AID_W-1:0]   b_aid  [NUM_BLK];
  logic [SZ_W-1:0]    b_sz   [NUM_BLK];
  logic [VPN_W-1:0]   b_mask [NUM_BLK];
  logic [NUM_BLK-1:0] b_hit;

  always_ff @(posedge clk) begin
    if (rst) n_vld <= '0;
    else if (wr_norm) n_vld[wr_slot] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr_norm) begin
      n_vpn[wr_slot] <= wr_vpn;
      n_ppn[wr_slot] <= wr_ppn;
      n_rt[wr_slot]  <= wr_rights;
      n_aid[wr_slot] <= wr_aid;
    end
  end

  generate
    for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
      always_ff @(posedge clk) begin
        if (rst) b_vld[g] <= 1'b0;
        else if (wr_blk && wr_bslot == BIDX_W'(g)) b_vld[g] <= 1'b1;
      end
      always_ff @(posedge clk) begin
        if (wr_blk && wr_bslot == BIDX_W'(g)) begin
          b_vpn[g] <= wr_vpn;
          b_ppn[g] <= wr_ppn;
          b_rt[g]  <= wr_rights;
          b_aid[g] <= wr_aid;
          b_sz[g]  <= wr_sz;
        end
      end
      assign b_mask[g] = (VPN_W'(1) << b_sz[g]) - VPN_W'(1);
      assign b_hit[g]  = b_vld[g] &&
                         ((b_vpn[g] & ~b_mask[g]) == (lk_vpn & ~b_mask[g]));
    end
    for (genvar g = 0; g < NUM_ENT; g++) begin : g_ent
      assign n_hit[g] = n_vld[g] && (n_vpn[g] == lk_vpn);
    end
  endgenerate

  always_comb begin
    found  = 1'b0;
    ppn    = '0;
    aid    = '0;
    rights = '0;
    for (int i = NUM_ENT - 1; i >= 0; i--) begin
      if (n_hit[i]) begin
        found  = 1'b1;
        ppn    = n_ppn[i];
        aid    = n_aid[i];
        rights = n_rt[i];
      end
    end
    for (int i = NUM_BLK - 1; i >= 0; i--) begin
      if (b_hit[i]) begin
        found  = 1'b1;
        ppn    = (b_ppn[i] & ~PPN_W'(b_mask[i])) | PPN_W'(lk_vpn & b_mask[i]);
        aid    = b_aid[i];
        rights = b_rt[i];
      end
    end
  end

  AST_INSTALL_VALID: assert property (@(posedge clk) disable iff (rst)
    wr_norm |=> n_vld[$past(wr_slot)]); // R8
  AST_RANGE_KEEPS_NORMAL: assert property (@(posedge clk) disable iff (rst)
    (wr_blk && !wr_norm) |=> n_vld == $past(n_vld)); // R8
endmodule

// File: rtl/xlat_buf.sv
module xlat_buf #(
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 16,
  parameter int AID_W   = 8,
  parameter int SZ_W    = 4,
  parameter int NUM_ENT = 8,
  parameter int NUM_BLK = 2,
  localparam int IDX_W  = $clog2(NUM_ENT),
  localparam int BIDX_W = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [VPN_W-1:0]  req_vpn,
  input  logic [1:0]        req_kind,
  input  logic [1:0]        req_priv,
  input  logic              d_virt,
  input  logic              i_virt,
  input  logic [AID_W-1:0]  pid0,
  input  logic [AID_W-1:0]  pid1,
  input  logic [AID_W-1:0]  pid2,
  input  logic [AID_W-1:0]  pid3,
  input  logic              ins_valid,
  input  logic              ins_blk,
  input  logic [BIDX_W-1:0] ins_bslot,
  input  logic [VPN_W-1:0]  ins_vpn,
  input  logic [PPN_W-1:0]  ins_ppn,
  input  logic [4:0]        ins_rights,
  input  logic [AID_W-1:0]  ins_aid,
  input  logic [SZ_W-1:0]   ins_sz,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic              rsp_miss,
  output logic              rsp_prot_flt,
  output logic              rsp_rights_flt,
  output logic [PPN_W-1:0]  rsp_ppn
);
  import xb_pkg::*;

  logic             wr_norm, wr_blk, virt;
  logic [IDX_W-1:0] slot;
  logic             lk_found, prot_ok, rights_ok;
  logic [PPN_W-1:0] lk_ppn;
  logic [AID_W-1:0] lk_aid;
  logic [4:0]       lk_rights;

  assign wr_norm = ins_valid && !ins_blk;
  assign wr_blk  = ins_valid && ins_blk && (int'(ins_bslot) < NUM_BLK);
  assign virt    = (req_kind == XB_EXEC) ? i_virt : d_virt;

  xb_rr_ptr #(.NUM_ENT(NUM_ENT)) u_ptr (
    .clk(clk), .rst(rst), .adv(wr_norm), .ptr(slot)
  );

  xb_lookup #(
    .VPN_W(VPN_W), .PPN_W(PPN_W), .AID_W(AID_W), .SZ_W(SZ_W),
    .NUM_ENT(NUM_ENT), .NUM_BLK(NUM_BLK)
  ) u_lk (
    .clk(clk), .rst(rst),
    .wr_norm(wr_norm), .wr_slot(slot),
    .wr_blk(wr_blk), .wr_bslot(ins_bslot),
    .wr_vpn(ins_vpn), .wr_ppn(ins_ppn), .wr_rights(ins_rights),
    .wr_aid(ins_aid), .wr_sz(ins_sz),
    .lk_vpn(req_vpn),
    .found(lk_found), .ppn(lk_ppn), .aid(lk_aid), .rights(lk_rights)
  );

  xb_perm #(.AID_W(AID_W)) u_perm (
    .aid(lk_aid), .rights(lk_rights),
    .pid0(pid0), .pid1(pid1), .pid2(pid2), .pid3(pid3),
    .kind(req_kind), .priv(req_priv),
    .prot_ok(prot_ok), .rights_ok(rights_ok)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid      <= 1'b0;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_prot_flt   <= 1'b0;
      rsp_rights_flt <= 1'b0;
      rsp_ppn        <= '0;
    end else begin
      rsp_valid      <= req_valid;
      rsp_hit        <= 1'b0;
      rsp_miss       <= 1'b0;
      rsp_prot_flt   <= 1'b0;
      rsp_rights_flt <= 1'b0;
      rsp_ppn        <= '0;
      if (req_valid) begin
        if (!virt) begin
          rsp_hit <= 1'b1;
          rsp_ppn <= req_vpn[PPN_W-1:0];
        end else if (!lk_found) begin
          rsp_miss <= 1'b1;
        end else if (!prot_ok) begin
          rsp_prot_flt <= 1'b1;
        end else if (!rights_ok) begin
          rsp_rights_flt <= 1'b1;
        end else begin
          rsp_hit <= 1'b1;
          rsp_ppn <= lk_ppn;
        end
      end
    end
  end

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> $countones({rsp_hit, rsp_miss, rsp_prot_flt, rsp_rights_flt}) == 1); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !rsp_valid |-> !(rsp_hit || rsp_miss || rsp_prot_flt || rsp_rights_flt)); // R2
  AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid); // R2
  AST_BYPASS_PASS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !virt) |=> rsp_hit && rsp_ppn == $past(req_vpn[PPN_W-1:0])); // R3
  AST_SHARED_AID: assert property (@(posedge clk) disable iff (rst)
    (req_valid && virt && lk_found && lk_aid == '0) |=> !rsp_prot_flt); // R6
  AST_NO_MATCH_MISS: assert property (@(posedge clk) disable iff (rst)
    (req_valid && virt && !lk_found) |=> rsp_miss && rsp_ppn == '0); // R9
endmodule

// File: tb/sim_xlat_buf.sv
module sim_xlat_buf;
  localparam int CLK_PERIOD = 10;
  localparam int VPN_W = 20, PPN_W = 16, AID_W = 8, SZ_W = 4;
  localparam int NUM_ENT = 8, NUM_BLK = 2, BIDX_W = 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 0, d_virt = 0, i_virt = 0;
  logic [VPN_W-1:0] req_vpn = '0;
  logic [1:0] req_kind = 0, req_priv = 0;
  logic [AID_W-1:0] pid0 = 0, pid1 = 0, pid2 = 0, pid3 = 0;
  logic ins_valid = 0, ins_blk = 0;
  logic [BIDX_W-1:0] ins_bslot = 0;
  logic [VPN_W-1:0] ins_vpn = 0;
  logic [PPN_W-1:0] ins_ppn = 0;
  logic [4:0] ins_rights = 0;
  logic [AID_W-1:0] ins_aid = 0;
  logic [SZ_W-1:0] ins_sz = 0;
  logic rsp_valid, rsp_hit, rsp_miss, rsp_prot_flt, rsp_rights_flt;
  logic [PPN_W-1:0] rsp_ppn;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  localparam logic [4:0] RT_ALL = 5'b111_11;
  localparam logic [4:0] RT_RD1 = 5'b100_01;

  always #(CLK_PERIOD/2) clk = ~clk;

  xlat_buf u0 (.*);

  task automatic check_rsp(input logic eh, em, ep, er, input logic [PPN_W-1:0] eppn,
                           input string tag);
    logic [4:0] act, exp;
    act = {rsp_valid, rsp_hit, rsp_miss, rsp_prot_flt, rsp_rights_flt};
    exp = {1'b1, eh, em, ep, er};
    checks++;
    if (act !== exp || rsp_ppn !== eppn) begin
      fails++;
      $display("FAIL %s: flags v/h/m/p/r=%b ppn=%h, expected %b ppn=%h",
               tag, act, rsp_ppn, exp, eppn);
    end
  endtask

  task automatic lookup(input logic [VPN_W-1:0] vpn, input logic [1:0] kind,
                        input logic [1:0] priv);
    @(negedge clk);
    req_valid = 1; req_vpn = vpn; req_kind = kind; req_priv = priv;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic install(input logic blk, input logic [BIDX_W-1:0] bslot,
                         input logic [VPN_W-1:0] vpn, input logic [PPN_W-1:0] ppn,
                         input logic [4:0] rt, input logic [AID_W-1:0] aid,
                         input logic [SZ_W-1:0] sz);
    @(negedge clk);
    ins_valid = 1; ins_blk = blk; ins_bslot = bslot; ins_vpn = vpn;
    ins_ppn = ppn; ins_rights = rt; ins_aid = aid; ins_sz = sz;
    @(negedge clk);
    ins_valid = 0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1;
    repeat (2) @(negedge clk);
    rst = 0;
  endtask

  task automatic t_reset();
    do_reset();
    checks++;
    if (rsp_valid !== 1'b0) begin
      fails++;
      $display("FAIL R1: rsp_valid=%b expected 0", rsp_valid);
    end
    d_virt = 1; i_virt = 1;
    lookup(20'h00005, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R1 R9 empty miss");
    lookup(20'h00000, 2'b10, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R1 range slots empty");
  endtask

  task automatic t_bypass();
    d_virt = 0; i_virt = 1;
    lookup(20'hABCDE, 2'b00, 2'd3);
    check_rsp(1, 0, 0, 0, 16'hBCDE, "R3 data bypass");
    d_virt = 1; i_virt = 0;
    lookup(20'h12345, 2'b10, 2'd3);
    check_rsp(1, 0, 0, 0, 16'h2345, "R3 fetch bypass");
    lookup(20'h12345, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R3 data stays virtual");
    i_virt = 1;
  endtask

  task automatic t_normal();
    pid0 = 8'h11;
    install(0, 0, 20'h00100, 16'h002A, RT_ALL, 8'h11, 0);
    lookup(20'h00100, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h002A, "R4 read hit");
    lookup(20'h00100, 2'b10, 2'd3);
    check_rsp(1, 0, 0, 0, 16'h002A, "R4 exec hit");
    lookup(20'h00101, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R9 neighbour miss");
  endtask

  task automatic t_prot();
    install(0, 0, 20'h00200, 16'h0200, RT_ALL, 8'h33, 0);
    lookup(20'h00200, 2'b00, 2'd0);
    check_rsp(0, 0, 1, 0, 16'h0, "R6 foreign id");
    lookup(20'h00200, 2'b11, 2'd0);
    check_rsp(0, 0, 1, 0, 16'h0, "R7 prot precedence");
    pid2 = 8'h33;
    lookup(20'h00200, 2'b01, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0200, "R6 pid2 match");
    pid2 = 8'h00; pid3 = 8'h33;
    lookup(20'h00200, 2'b01, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0200, "R6 pid3 match");
    pid3 = 8'h00;
    install(0, 0, 20'h00201, 16'h0201, RT_ALL, 8'h00, 0);
    lookup(20'h00201, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0201, "R6 shared id");
  endtask

  task automatic t_rights();
    install(0, 0, 20'h00300, 16'h0300, RT_RD1, 8'h11, 0);
    lookup(20'h00300, 2'b00, 2'd1);
    check_rsp(1, 0, 0, 0, 16'h0300, "R7 read at limit");
    lookup(20'h00300, 2'b01, 2'd0);
    check_rsp(0, 0, 0, 1, 16'h0, "R7 write denied");
    lookup(20'h00300, 2'b10, 2'd0);
    check_rsp(0, 0, 0, 1, 16'h0, "R7 exec denied");
    lookup(20'h00300, 2'b00, 2'd2);
    check_rsp(0, 0, 0, 1, 16'h0, "R7 privilege too low");
  endtask

  task automatic t_block();
    install(1, 0, 20'h04000, 16'h0800, 5'b110_11, 8'h00, 4'd4);
    lookup(20'h04007, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0807, "R5 inside range");
    lookup(20'h0400F, 2'b01, 2'd3);
    check_rsp(1, 0, 0, 0, 16'h080F, "R5 range top");
    lookup(20'h04010, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R5 past range");
    install(0, 0, 20'h04003, 16'h0055, RT_ALL, 8'h00, 0);
    lookup(20'h04003, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0803, "R5 range precedence");
  endtask

  task automatic t_rr();
    do_reset();
    for (int i = 0; i < NUM_ENT; i++)
      install(0, 0, 20'h00500 + 20'(i), 16'(i + 1), RT_ALL, 8'h00, 0);
    for (int i = 0; i < NUM_ENT; i++) begin
      lookup(20'h00500 + 20'(i), 2'b00, 2'd0);
      check_rsp(1, 0, 0, 0, 16'(i + 1), "R8 fill");
    end
    install(0, 0, 20'h00600, 16'h0600, RT_ALL, 8'h00, 0);
    lookup(20'h00500, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R8 oldest evicted");
    lookup(20'h00501, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0002, "R8 next kept");
    lookup(20'h00600, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0600, "R8 wrapped install");
    install(1, 1, 20'h07000, 16'h0700, RT_ALL, 8'h00, 4'd0);
    for (int i = 1; i < NUM_ENT; i++) begin
      lookup(20'h00500 + 20'(i), 2'b00, 2'd0);
      check_rsp(1, 0, 0, 0, 16'(i + 1), "R8 range install evicts nothing");
    end
    install(0, 0, 20'h00601, 16'h0601, RT_ALL, 8'h00, 0);
    lookup(20'h00501, 2'b00, 2'd0);
    check_rsp(0, 1, 0, 0, 16'h0, "R8 order unmoved by range");
    lookup(20'h00502, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0003, "R8 slot 2 kept");
    lookup(20'h07000, 2'b00, 2'd0);
    check_rsp(1, 0, 0, 0, 16'h0700, "R8 range survives");
  endtask

  initial begin
    t_reset();
    t_bypass();
    t_normal();
    t_prot();
    t_rights();
    t_block();
    t_rr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule